// File: doc/BRIEF.md
# Dual-Variant BCD Adder-Subtractor

This is a purely combinational 8-bit add/subtract unit for the accumulator datapath of a small 8-bit processor. It works in plain binary or in packed BCD (two decimal digits per byte). A variant input picks one of two flag behaviours. The older one takes some flags from intermediate or binary values during decimal operations. The newer one produces correct N and Z flags from the decimal result, at the cost of one extra cycle.

The surrounding sequencer supplies the accumulator, the operand, the incoming carry, the decimal-mode flag, the operation and the variant. It takes back the result byte, the four arithmetic flags and a one-bit request to stretch the instruction by one cycle. Instruction decode, register storage and memory access sit outside the block.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (`decimal_i`=0, `sub_i`=0) gives `sum_o` = (A + B + Cin) mod 256. `carry_o` is set when the sum exceeds 255. `ovf_o` is set on two's-complement overflow. `neg_o` is bit 7 of `sum_o`, and `zero_o` is set when `sum_o` is 0. This holds for both variants.
- R2: Binary subtract (`decimal_i`=0, `sub_i`=1) gives `sum_o` = (A - B - (1 - Cin)) mod 256. `carry_o` is 1 when no borrow occurs. `ovf_o` flags signed overflow. N and Z are taken from `sum_o`. This holds for both variants.
- R3: In decimal add with both operands valid BCD (each nibble 0 to 9), `sum_o` is the BCD encoding of (a + b + Cin) mod 100, where a and b are the decimal values. `carry_o` is set when a + b + Cin is 100 or more. This holds for both variants.
- R4: In decimal subtract with both operands valid BCD, `sum_o` is the BCD encoding of (a - b - (1 - Cin)) mod 100. `carry_o` is 1 when that difference is not negative. This holds for both variants.
- R5: With `cmos_i`=0, decimal add sets `zero_o` only when the plain binary (A + B + Cin) mod 256 is 0, whatever the decimal result is.
- R6: With `cmos_i`=0, decimal add forms an intermediate T in two steps. First, L = low(A) + low(B) + Cin, plus 6 if L > 9. Then T = high(A)·16 + high(B)·16 + (L mod 16), plus 16 if L > 15. `neg_o` is bit 7 of T. `ovf_o` is set when A and B have equal bit 7 and bit 7 of T differs from that of A. The result adds 0x60 to T when T masked with 0x1F0 is above 0x90, and `carry_o` is set when the adjusted value masked with 0xFF0 is above 0xF0.
- R7: With `cmos_i`=0, decimal subtract takes N, Z, C and V from the binary difference A - B - (1 - Cin), exactly as in R2. Only `sum_o` is decimal-corrected.
- R8: With `cmos_i`=1, decimal add and decimal subtract take `neg_o` from bit 7 of `sum_o`, and `zero_o` is set when `sum_o` is 0.
- R9: With `cmos_i`=1, decimal add forms S in two steps. First, L = low(A) + low(B) + Cin, and L becomes 16 + ((L + 6) mod 16) when it is 10 or more. Then S = L + high(A)·16 + high(B)·16. `ovf_o` is set only if A and B have equal bit 7, and then only when S is in 0x80 to 0x9F or in 0xA0 to 0x17F. `carry_o` is set when S is 0xA0 or more. The result is S + 0x60 in that case, and S otherwise.
- R10: With `cmos_i`=1, decimal subtract forms H = 0xF0 + high(A)·16 - high(B)·16, plus 16 if 15 + low(A) - low(B) + Cin is 16 or more. `ovf_o` is set only if A and B differ in bit 7, and then only when H is in 0x80 to 0x17F. `carry_o` is set when H is 0x100 or more.
- R11: `extra_cyc_o` is 1 exactly when `decimal_i`=1 and `cmos_i`=1, for both add and subtract. It is 0 in binary mode and with `cmos_i`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| carry_i | input | 1 | Incoming carry (for subtract, 0 means borrow) |
| decimal_i | input | 1 | 1 selects packed-BCD arithmetic |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| cmos_i | input | 1 | 0 = older flag behaviour, 1 = newer flag behaviour |
| sum_o | output | 8 | Result byte |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / no-borrow flag |
| ovf_o | output | 1 | Overflow flag |
| extra_cyc_o | output | 1 | Request for one extra execution cycle |

## Verification
The embedded checks only judge the block when every input bit is known. The checks on decimal-result validity further assume that both operands already hold valid BCD digits. For non-BCD operands, the decimal outputs are defined only by the nibble formulas, not by decimal meaning. The stimulus drives known values from the first edge and applies fixed corner operands under every mode combination. It then splits its random traffic between full-range bytes, which exercise the nibble formulas on invalid digits, and BCD-only bytes, which exercise the decimal meaning.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    // Operand width; the nibble corrections below assume two digits.
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int SUM_W  = DATA_W + 1;
    localparam int WIDE_W = DATA_W + 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [WIDE_W-1:0] wide_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef enum logic { VAR_NMOS = 1'b0, VAR_CMOS = 1'b1 } variant_e;
    typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        byte_t  res;
        flags_t fl;
    } alu_res_t;

    typedef struct packed {
        byte_t a;
        byte_t b;
        logic  cin;
        op_e   op;
    } alu_in_t;

    // Constant widened to the internal arithmetic width.
    function automatic wide_t wc(input int val);
        return wide_t'(val);
    endfunction

    // Low digit, right aligned.
    function automatic wide_t lo_dig(input byte_t x);
        return wide_t'(x[NIB_W-1:0]);
    endfunction

    // High digit kept at its weight of sixteen.
    function automatic wide_t hi_dig(input byte_t x);
        return wide_t'({x[DATA_W-1:NIB_W], {NIB_W{1'b0}}});
    endfunction

    function automatic logic bcd_ok(input byte_t x);
        return (x[DATA_W-1:NIB_W] <= 4'd9) && (x[NIB_W-1:0] <= 4'd9);
    endfunction

endpackage

// File: rtl/bcd_bin_path.sv
module bcd_bin_path
    import bcd_alu_pkg::*;
(
    input  alu_in_t  in_s,
    output alu_res_t out_s
);

    byte_t b_eff;
    sum_t  total;

    always_comb begin
        b_eff = (in_s.op == OP_SUB) ? ~in_s.b : in_s.b;
        total = {1'b0, in_s.a} + {1'b0, b_eff} + SUM_W'(in_s.cin);
        out_s.res  = total[DATA_W-1:0];
        out_s.fl.c = total[DATA_W];
        out_s.fl.n = total[DATA_W-1];
        out_s.fl.z = (total[DATA_W-1:0] == '0);
        out_s.fl.v = (in_s.a[DATA_W-1] == b_eff[DATA_W-1]) &&
                     (total[DATA_W-1] != in_s.a[DATA_W-1]);
    end

    always_comb begin
        if (!$isunknown(in_s) && in_s.op == OP_SUB) begin
            // R2
            bin_sub_res_chk: assert (out_s.res ==
                byte_t'(in_s.a - in_s.b - byte_t'(!in_s.cin)));
        end
    end

endmodule

// File: rtl/bcd_nmos_dec.sv
module bcd_nmos_dec
    import bcd_alu_pkg::*;
(
    input  alu_in_t  in_s,
    output alu_res_t out_s
);

    // add path
    wide_t lo_a, mid, fin;
    byte_t bin_sum;
    // subtract path
    wide_t dif, slo, shi, sv;
    logic  borrow;

    always_comb begin
        bin_sum = in_s.a + in_s.b + byte_t'(in_s.cin);

        lo_a = lo_dig(in_s.a) + lo_dig(in_s.b) + wide_t'(in_s.cin);
        if (lo_a > wc(9))
            lo_a = lo_a + wc(6);
        mid = (lo_a & wc(15)) + hi_dig(in_s.a) + hi_dig(in_s.b) +
              ((lo_a > wc(15)) ? wc(16) : wc(0));
        fin = mid;
        if ((mid & wc('h1F0)) > wc('h90))
            fin = mid + wc('h60);

        dif = {2'b00, in_s.a} - {2'b00, in_s.b} - wide_t'(!in_s.cin);
        borrow = |dif[WIDE_W-1:DATA_W];

        slo = lo_dig(in_s.a) - lo_dig(in_s.b) - wide_t'(!in_s.cin);
        if (slo[NIB_W]) begin
            shi = hi_dig(in_s.a) - hi_dig(in_s.b) - wc(16);
            sv  = ((slo - wc(6)) & wc(15)) | shi;
        end else begin
            shi = hi_dig(in_s.a) - hi_dig(in_s.b);
            sv  = (slo & wc(15)) | shi;
        end
        if (sv[DATA_W])
            sv = sv - wc('h60);

        if (in_s.op == OP_ADD) begin
            out_s.res  = fin[DATA_W-1:0];
            out_s.fl.c = (fin & wc('h3F0)) > wc('hF0);
            out_s.fl.z = (bin_sum == '0);
            out_s.fl.n = mid[DATA_W-1];
            out_s.fl.v = (in_s.a[DATA_W-1] == in_s.b[DATA_W-1]) &&
                         (in_s.a[DATA_W-1] != mid[DATA_W-1]);
        end else begin
            out_s.res  = sv[DATA_W-1:0];
            out_s.fl.c = !borrow;
            out_s.fl.z = (dif[DATA_W-1:0] == '0);
            out_s.fl.n = dif[DATA_W-1];
            out_s.fl.v = (in_s.a[DATA_W-1] != in_s.b[DATA_W-1]) &&
                         (in_s.a[DATA_W-1] != dif[DATA_W-1]);
        end
    end

    always_comb begin
        if (!$isunknown(in_s)) begin
            if (bcd_ok(in_s.a) && bcd_ok(in_s.b)) begin
                // R3 / R4
                nmos_bcd_digit_chk: assert (bcd_ok(out_s.res));
            end
            if (in_s.op == OP_SUB) begin
                // R7
                nmos_sub_carry_chk: assert (out_s.fl.c ==
                    (int'(in_s.a) >= int'(in_s.b) + int'(!in_s.cin)));
            end
        end
    end

endmodule

// File: rtl/bcd_cmos_dec.sv
module bcd_cmos_dec
    import bcd_alu_pkg::*;
(
    input  alu_in_t  in_s,
    output alu_res_t out_s
);

    wide_t lo_s, sum_s, t_s, h_s;
    logic  v_add, v_sub, c_add, c_sub;
    byte_t r_add, r_sub, r_sel;

    always_comb begin
        // decimal add
        v_add = (in_s.a[DATA_W-1] == in_s.b[DATA_W-1]);
        lo_s  = lo_dig(in_s.a) + lo_dig(in_s.b) + wide_t'(in_s.cin);
        if (lo_s >= wc(10))
            lo_s = wc(16) | ((lo_s + wc(6)) & wc(15));
        sum_s = lo_s + hi_dig(in_s.a) + hi_dig(in_s.b);
        if (sum_s >= wc('hA0)) begin
            c_add = 1'b1;
            if (sum_s >= wc('h180))
                v_add = 1'b0;
            r_add = byte_t'(sum_s + wc('h60));
        end else begin
            c_add = 1'b0;
            if (sum_s < wc('h80))
                v_add = 1'b0;
            r_add = byte_t'(sum_s);
        end

        // decimal subtract
        v_sub = (in_s.a[DATA_W-1] != in_s.b[DATA_W-1]);
        t_s   = wc(15) + lo_dig(in_s.a) - lo_dig(in_s.b) + wide_t'(in_s.cin);
        if (t_s < wc(16)) begin
            h_s = wc(0);
            t_s = t_s - wc(6);
        end else begin
            h_s = wc(16);
            t_s = t_s - wc(16);
        end
        h_s = h_s + wc('hF0) + hi_dig(in_s.a) - hi_dig(in_s.b);
        if (h_s < wc('h100)) begin
            c_sub = 1'b0;
            if (h_s < wc('h80))
                v_sub = 1'b0;
            h_s = h_s - wc('h60);
        end else begin
            c_sub = 1'b1;
            if (h_s >= wc('h180))
                v_sub = 1'b0;
        end
        r_sub = byte_t'(h_s + t_s);

        r_sel      = (in_s.op == OP_SUB) ? r_sub : r_add;
        out_s.res  = r_sel;
        out_s.fl.c = (in_s.op == OP_SUB) ? c_sub : c_add;
        out_s.fl.v = (in_s.op == OP_SUB) ? v_sub : v_add;
        out_s.fl.n = r_sel[DATA_W-1];
        out_s.fl.z = (r_sel == '0);
    end

    always_comb begin
        if (!$isunknown(in_s)) begin
            if (bcd_ok(in_s.a) && bcd_ok(in_s.b)) begin
                // R3 / R4
                cmos_bcd_digit_chk: assert (bcd_ok(out_s.res));
            end
            if (in_s.op == OP_ADD && in_s.a[DATA_W-1] != in_s.b[DATA_W-1]) begin
                // R9
                cmos_add_sign_chk: assert (!out_s.fl.v);
            end
            if (in_s.op == OP_SUB && in_s.a[DATA_W-1] == in_s.b[DATA_W-1]) begin
                // R10
                cmos_sub_sign_chk: assert (!out_s.fl.v);
            end
        end
    end

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_alu_pkg::*;
(
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic       carry_i,
    input  logic       decimal_i,
    input  logic       sub_i,
    input  logic       cmos_i,
    output logic [7:0] sum_o,
    output logic       neg_o,
    output logic       zero_o,
    output logic       carry_o,
    output logic       ovf_o,
    output logic       extra_cyc_o
);

    alu_in_t  in_s;
    alu_res_t bin_r, nmos_r, cmos_r, sel_r;
    variant_e var_s;

    assign in_s  = '{a: acc_i, b: opnd_i, cin: carry_i, op: op_e'(sub_i)};
    assign var_s = variant_e'(cmos_i);

    bcd_bin_path u_bin (.in_s(in_s), .out_s(bin_r));
    bcd_nmos_dec u_nmos (.in_s(in_s), .out_s(nmos_r));
    bcd_cmos_dec u_cmos (.in_s(in_s), .out_s(cmos_r));

    always_comb begin
        if (!decimal_i)
            sel_r = bin_r;
        else if (var_s == VAR_CMOS)
            sel_r = cmos_r;
        else
            sel_r = nmos_r;
    end

    assign sum_o       = sel_r.res;
    assign neg_o       = sel_r.fl.n;
    assign zero_o      = sel_r.fl.z;
    assign carry_o     = sel_r.fl.c;
    assign ovf_o       = sel_r.fl.v;
    assign extra_cyc_o = decimal_i && (var_s == VAR_CMOS);

    always_comb begin
        if (!$isunknown({acc_i, opnd_i, carry_i, decimal_i, sub_i, cmos_i})) begin
            // R11
            extra_cyc_chk: assert (!extra_cyc_o || (decimal_i && cmos_i));
            if (decimal_i && cmos_i) begin
                // R8
                cmos_nz_chk: assert ((zero_o == (sum_o == 8'h00)) &&
                                     (neg_o == sum_o[7]));
            end
            if (!decimal_i && !sub_i) begin
                // R1
                bin_add_chk: assert ({carry_o, sum_o} ==
                    9'({1'b0, acc_i} + {1'b0, opnd_i} + 9'(carry_i)));
            end
        end
    end

endmodule

// File: tb/sim_bcd_addsub_unit.sv
`timescale 1ns/1ps
module sim_bcd_addsub_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0] acc, opnd;
    logic       cin, dec, sub, cm;
    logic [7:0] sum;
    logic       n, z, c, v, x;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    bcd_addsub_unit u0 (
        .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .decimal_i(dec),
        .sub_i(sub), .cmos_i(cm), .sum_o(sum), .neg_o(n), .zero_o(z),
        .carry_o(c), .ovf_o(v), .extra_cyc_o(x)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (a=%02h b=%02h c=%0d d=%0d s=%0d m=%0d)",
                     tag, what, act, exp, acc, opnd, cin, dec, sub, cm);
        end
    endtask

    // Behavioural reference: returns {res[7:0], n, z, c, v, x}
    function automatic logic [12:0] model(int a, int b, int ci, int d, int s, int m);
        int r, fn, fz, fc, fv, lo, t, hi, bb, df;
        fn = 0; fz = 0; fc = 0; fv = 0;
        if (d == 0) begin
            bb = s ? (255 - b) : b;
            t  = a + bb + ci;
            r  = t & 255;
            fc = (t > 255);
            fv = (((a ^ r) & (bb ^ r) & 128) != 0);
            fn = r >> 7;
            fz = (r == 0);
        end else if (m == 0 && s == 0) begin
            lo = (a & 15) + (b & 15) + ci;
            if (lo > 9) lo += 6;
            t = (a & 240) + (b & 240) + (lo & 15) + ((lo > 15) ? 16 : 0);
            fz = (((a + b + ci) & 255) == 0);
            fn = (t >> 7) & 1;
            fv = ((((a ^ t) & 128) != 0) && (((a ^ b) & 128) == 0));
            if ((t & 'h1F0) > 'h90) t += 'h60;
            fc = ((t & 'hFF0) > 'hF0);
            r = t & 255;
        end else if (m == 0) begin
            df = a - b - (1 - ci);
            fc = (df >= 0);
            fn = (df >> 7) & 1;
            fz = ((df & 255) == 0);
            fv = ((((a ^ df) & 128) != 0) && (((a ^ b) & 128) != 0));
            lo = (a & 15) - (b & 15) - (1 - ci);
            if (lo < 0) begin
                hi = (a & 240) - (b & 240) - 16;
                lo = (lo - 6) & 15;
            end else begin
                hi = (a & 240) - (b & 240);
            end
            t = hi + lo;
            if ((t & 'h100) != 0) t -= 'h60;
            r = t & 255;
        end else if (s == 0) begin
            fv = (((a ^ b) & 128) == 0);
            lo = (a & 15) + (b & 15) + ci;
            if (lo >= 10) lo = 16 | ((lo + 6) & 15);
            t = lo + (a & 240) + (b & 240);
            if (t >= 'hA0) begin
                fc = 1;
                if (t >= 'h180) fv = 0;
                t += 'h60;
            end else if (t < 'h80) fv = 0;
            r = t & 255;
            fn = r >> 7;
            fz = (r == 0);
        end else begin
            fv = (((a ^ b) & 128) != 0);
            t = 15 + (a & 15) - (b & 15) + ci;
            if (t < 16) begin hi = 0; t -= 6; end
            else begin hi = 16; t -= 16; end
            hi += 240 + (a & 240) - (b & 240);
            if (hi < 256) begin
                fc = 0;
                if (hi < 128) fv = 0;
                hi -= 96;
            end else begin
                fc = 1;
                if (hi >= 384) fv = 0;
            end
            r = (hi + t) & 255;
            fn = r >> 7;
            fz = (r == 0);
        end
        return {r[7:0], fn[0], fz[0], fc[0], fv[0], 1'(d != 0 && m != 0)};
    endfunction

    function automatic int dval(int h);
        return (h >> 4) * 10 + (h & 15);
    endfunction

    task automatic run_vec(input int a, input int b, input int ci, input int d,
                           input int s, input int m);
        logic [12:0] e;
        string trs, tnz_n, tnz_z, tv;
        int da, db, tot;
        @(posedge clk);
        acc = 8'(a); opnd = 8'(b); cin = 1'(ci); dec = 1'(d); sub = 1'(s); cm = 1'(m);
        @(negedge clk);
        e = model(a, b, ci, d, s, m);
        trs = (d == 0) ? (s ? "R2" : "R1") : (s ? "R4" : "R3");
        if (d == 0) begin tnz_n = trs; tnz_z = trs; tv = trs; end
        else if (m != 0) begin tnz_n = "R8"; tnz_z = "R8"; tv = s ? "R10" : "R9"; end
        else if (s == 0) begin tnz_n = "R6"; tnz_z = "R5"; tv = "R6"; end
        else begin tnz_n = "R7"; tnz_z = "R7"; tv = "R7"; end
        chk(trs, "result", int'(sum), int'(e[12:5]));
        chk(tnz_n, "neg", int'(n), int'(e[4]));
        chk(tnz_z, "zero", int'(z), int'(e[3]));
        chk((d != 0 && m == 0 && s != 0) ? "R7" : trs, "carry", int'(c), int'(e[2]));
        chk(tv, "ovf", int'(v), int'(e[1]));
        chk("R11", "extra", int'(x), int'(e[0]));
        // Independent decimal-meaning check for valid BCD operands
        if (d != 0 && (a >> 4) <= 9 && (a & 15) <= 9 && (b >> 4) <= 9 && (b & 15) <= 9) begin
            da = dval(a); db = dval(b);
            if (s == 0) begin
                tot = da + db + ci;
                chk("R3", "bcd sum", int'(sum), ((tot % 100) / 10) * 16 + (tot % 10));
                chk("R3", "bcd carry", int'(c), int'(tot >= 100));
            end else begin
                tot = da - db - (1 - ci);
                chk("R4", "bcd diff", int'(sum),
                    (((tot + 100) % 100) / 10) * 16 + ((tot + 100) % 10));
                chk("R4", "bcd borrow", int'(c), int'(tot >= 0));
            end
        end
    endtask

    int corner_a[12] = '{'h00, 'h99, 'h00, 'h50, 'h7F, 'h80, 'hFF, 'h0F, 'h9A, 'h19, 'h80, 'h45};
    int corner_b[12] = '{'h00, 'h01, 'h01, 'h50, 'h01, 'h01, 'hFF, 'h0F, 'h66, 'h28, 'h80, 'h45};

    initial begin
        acc = 8'h00; opnd = 8'h00; cin = 1'b0; dec = 1'b0; sub = 1'b0; cm = 1'b0;
        repeat (3) @(negedge clk);
        // reset-time state with all inputs at zero: R1
        chk("R1", "reset result", int'(sum), 0);
        chk("R1", "reset zero", int'(z), 1);
        chk("R11", "reset extra", int'(x), 0);
        rst = 1'b0;

        // Hand-worked quirk: 0x99 + 0x01, older variant (R5, R6)
        run_vec('h99, 'h01, 0, 1, 0, 0);
        chk("R6", "hand result", int'(sum), 'h00);
        chk("R5", "hand zero from binary", int'(z), 0);
        chk("R6", "hand neg from intermediate", int'(n), 1);
        chk("R3", "hand carry", int'(c), 1);
        // Same sum, newer variant (R8, R11)
        run_vec('h99, 'h01, 0, 1, 0, 1);
        chk("R8", "hand zero", int'(z), 1);
        chk("R8", "hand neg", int'(n), 0);
        chk("R11", "hand extra", int'(x), 1);

        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 12; k++)
                        for (int ci = 0; ci < 2; ci++)
                            run_vec(corner_a[k], corner_b[k], ci, d, s, m);

        for (int i = 0; i < 4000; i++)
            run_vec(int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(1)), int'($urandom_range(1)),
                    int'($urandom_range(1)), int'($urandom_range(1)));

        for (int i = 0; i < 2000; i++)
            run_vec(int'($urandom_range(9)) * 16 + int'($urandom_range(9)),
                    int'($urandom_range(9)) * 16 + int'($urandom_range(9)),
                    int'($urandom_range(1)), 1,
                    int'($urandom_range(1)), int'($urandom_range(1)));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule